// File: doc/BRIEF.md
# Audio Frame Sequencer Controller

This block paces the slow housekeeping work of a four-voice retro sound unit. An external divider supplies two events: one when its tap bit falls and one when it rises. Nominally the fall arrives every 2048 machine cycles, or 512 Hz. A fall that comes early because software rewrote the divider is treated exactly like a natural one. Each serviced fall advances an eight-position step counter. From the step position the block decides whether to clock the channels' length counters, the frequency sweep, or the envelope step. Each rising event arms the envelope units, and each serviced fall fires them.

The block also keeps a separate serviced-event counter, and three sub-rates come from its low bits. Bit 0 is exported as the phase that trigger-time length logic consults. When the low two bits read 3, a 128 Hz sweep sub-tick is marked. When the low three bits read 7, an envelope countdown decrement is issued, which gives 64 Hz.

Power is controlled by a write strobe that carries the new power state. If power comes on while the divider bit is already high, the first fall is dropped. The counter is seeded to 1 so that later logic sees the same phase it would have seen had the dropped event been serviced.

Top module: `frame_seq`

## Requirements
- R1: While powered, each serviced falling event advances `step` by one, wrapping 7 to 0.
- R2: On a serviced fall, the step value before the advance decides the channel strobes. `len_clk` fires on steps 0, 2, 4 and 6. `sweep_clk` fires on steps 2 and 6. `env_step` fires on step 7.
- R3: `env_fire` pulses on every serviced falling event. `env_arm` pulses on every rising event while powered.
- R4: Every strobe is high for exactly one cycle, in the cycle after the event input was sampled high.
- R5: While powered off, and in any cycle that carries a power write, edge events are ignored: no strobe fires, and `step` and `ev_count` hold.
- R6: A power write of 0 while on clears `ev_count` and any pending skip, and leaves `step` unchanged. A power write of 1 while off sets `step` to 0 and `ev_count` to 0. A power write that matches the current state has no effect.
- R7: On power-on with `div_high`=1, `ev_count` is seeded to 1 and the first falling event after that produces no strobe and no step change. The next falling event is serviced normally except that `ev_count` does not increment.
- R8: Every other serviced falling event increments `ev_count` before decoding. The counter wraps from 255 to 0.
- R9: On a serviced fall, after the update, `env_dec` pulses if `ev_count[2:0]`==7 and `sweep_sub` pulses if `ev_count[1:0]`==3. Over 16 consecutive normal serviced events this gives exactly 4 `sweep_sub` and 2 `env_dec`.
- R10: `len_phase` always equals bit 0 of `ev_count`.
- R11: After reset the block is powered off, with `step`=0, `ev_count`=0 and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_fall | input | 1 | Divider tap fell (one-cycle event) |
| div_rise | input | 1 | Divider tap rose (one-cycle event) |
| pwr_wr | input | 1 | Power control write strobe |
| pwr_val | input | 1 | Power state carried by the write |
| div_high | input | 1 | Divider tap level at the time of the power write |
| len_clk | output | 1 | Length counter clock strobe |
| sweep_clk | output | 1 | Frequency sweep clock strobe |
| env_step | output | 1 | Envelope step strobe (step 7) |
| env_arm | output | 1 | Envelope arm strobe (rising event) |
| env_fire | output | 1 | Envelope fire strobe (serviced fall) |
| env_dec | output | 1 | Envelope countdown decrement strobe (64 Hz) |
| sweep_sub | output | 1 | Sweep sub-tick strobe (128 Hz) |
| len_phase | output | 1 | Extra-length-clock phase, bit 0 of `ev_count` |
| ev_count | output | CNT_W | Serviced-event counter |
| step | output | 3 | Current step position |

## Verification
The assertions check the relations that hold on every cycle:
- A sweep strobe never appears without a length strobe.
- A decrement strobe always coincides with a sweep sub-tick.
- Every strobe traces back to an event sampled one cycle earlier.
- Nothing fires in the cycle after a powered-off cycle.
- The step advances by one on each fire.

Only the bench's scenarios can show the order-dependent behaviour:
- the full step pattern over a wrap;
- the dropped first event and the non-incrementing event that follows it after a power-on with the divider high;
- a pending skip being cancelled by a power cycle;
- the 4-in-16 sub-tick count;
- the 8-bit wrap of the event counter.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_fall,
  input  logic             div_rise,
  input  logic             pwr_wr,
  input  logic             pwr_val,
  input  logic             div_high,
  output logic             len_clk,
  output logic             sweep_clk,
  output logic             env_step,
  output logic             env_arm,
  output logic             env_fire,
  output logic             env_dec,
  output logic             sweep_sub,
  output logic             len_phase,
  output logic [CNT_W-1:0] ev_count,
  output logic [2:0]       step
);

  logic powered, skip_q, noinc_q;

  wire turn_on  = pwr_wr &  pwr_val & ~powered;
  wire turn_off = pwr_wr & ~pwr_val &  powered;
  wire live     = powered & ~pwr_wr;
  wire [CNT_W-1:0] cnt_nx = noinc_q ? ev_count : ev_count + 1'b1;

  assign len_phase = ev_count[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      powered   <= 1'b0;
      skip_q    <= 1'b0;
      noinc_q   <= 1'b0;
      step      <= '0;
      ev_count  <= '0;
      len_clk   <= 1'b0;
      sweep_clk <= 1'b0;
      env_step  <= 1'b0;
      env_arm   <= 1'b0;
      env_fire  <= 1'b0;
      env_dec   <= 1'b0;
      sweep_sub <= 1'b0;
    end else begin
      len_clk   <= 1'b0;
      sweep_clk <= 1'b0;
      env_step  <= 1'b0;
      env_arm   <= 1'b0;
      env_fire  <= 1'b0;
      env_dec   <= 1'b0;
      sweep_sub <= 1'b0;
      if (turn_off) begin
        powered  <= 1'b0;
        ev_count <= '0;
        skip_q   <= 1'b0;
        noinc_q  <= 1'b0;
      end else if (turn_on) begin
        powered  <= 1'b1;
        step     <= '0;
        ev_count <= CNT_W'(div_high);
        skip_q   <= div_high;
        noinc_q  <= 1'b0;
      end else if (live) begin
        if (div_rise) env_arm <= 1'b1;
        if (div_fall) begin
          if (skip_q) begin
            skip_q  <= 1'b0;
            noinc_q <= 1'b1;
          end else begin
            noinc_q   <= 1'b0;
            ev_count  <= cnt_nx;
            env_fire  <= 1'b1;
            len_clk   <= ~step[0];
            sweep_clk <= (step == 3'd2) || (step == 3'd6);
            env_step  <= (step == 3'd7);
            env_dec   <= (cnt_nx[2:0] == 3'd7);
            sweep_sub <= (cnt_nx[1:0] == 2'd3);
            step      <= step + 3'd1;
          end
        end
      end
    end
  end

  p_sweep_in_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_clk |-> len_clk);

  p_strobe_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (env_fire | len_clk | env_dec | sweep_sub | env_step) |-> $past(div_fall));

  p_arm_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    env_arm |-> $past(div_rise));

  p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |=> !(env_fire | env_arm));

  p_step_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    env_fire |-> step == $past(step) + 3'd1);

  p_dec_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    env_dec |-> sweep_sub);

endmodule

// File: tb/frame_seq_tb.sv
module frame_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_fall = 1'b0, div_rise = 1'b0, pwr_wr = 1'b0, pwr_val = 1'b0, div_high = 1'b0;
  logic len_clk, sweep_clk, env_step, env_arm, env_fire, env_dec, sweep_sub, len_phase;
  logic [7:0] ev_count;
  logic [2:0] step;

  always #10 clk = ~clk;

  frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .div_fall(div_fall), .div_rise(div_rise),
    .pwr_wr(pwr_wr), .pwr_val(pwr_val), .div_high(div_high),
    .len_clk(len_clk), .sweep_clk(sweep_clk), .env_step(env_step),
    .env_arm(env_arm), .env_fire(env_fire), .env_dec(env_dec),
    .sweep_sub(sweep_sub), .len_phase(len_phase), .ev_count(ev_count), .step(step)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // mask bits: arm fire len sweep estep dec ssub
  function automatic logic [23:0] mk(input logic [1:0] op, input logic v, input logic h,
                                     input logic [6:0] m, input logic [7:0] c, input logic [2:0] s);
    return {op, v, h, m, 1'b0, c, 1'b0, s};
  endfunction

  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    mk(2'd0, 1'b0, 1'b0, 7'b0000000, 8'd0, 3'd0),
    mk(2'd2, 1'b1, 1'b0, 7'b0000000, 8'd0, 3'd0),
    mk(2'd0, 1'b0, 1'b0, 7'b0110000, 8'd1, 3'd1),
    mk(2'd0, 1'b0, 1'b0, 7'b0100000, 8'd2, 3'd2),
    mk(2'd0, 1'b0, 1'b0, 7'b0111001, 8'd3, 3'd3),
    mk(2'd1, 1'b0, 1'b0, 7'b1000000, 8'd3, 3'd3),
    mk(2'd0, 1'b0, 1'b0, 7'b0100000, 8'd4, 3'd4),
    mk(2'd0, 1'b0, 1'b0, 7'b0110000, 8'd5, 3'd5),
    mk(2'd0, 1'b0, 1'b0, 7'b0100000, 8'd6, 3'd6),
    mk(2'd0, 1'b0, 1'b0, 7'b0111011, 8'd7, 3'd7),
    mk(2'd0, 1'b0, 1'b0, 7'b0100100, 8'd8, 3'd0),
    mk(2'd2, 1'b0, 1'b0, 7'b0000000, 8'd0, 3'd0),
    mk(2'd1, 1'b0, 1'b0, 7'b0000000, 8'd0, 3'd0),
    mk(2'd2, 1'b1, 1'b1, 7'b0000000, 8'd1, 3'd0),
    mk(2'd0, 1'b0, 1'b0, 7'b0000000, 8'd1, 3'd0),
    mk(2'd0, 1'b0, 1'b0, 7'b0110000, 8'd1, 3'd1),
    mk(2'd0, 1'b0, 1'b0, 7'b0100000, 8'd2, 3'd2),
    mk(2'd2, 1'b1, 1'b0, 7'b0000000, 8'd2, 3'd2),
    mk(2'd0, 1'b0, 1'b0, 7'b0111001, 8'd3, 3'd3),
    mk(2'd2, 1'b0, 1'b0, 7'b0000000, 8'd0, 3'd3),
    mk(2'd0, 1'b0, 1'b0, 7'b0000000, 8'd0, 3'd3),
    mk(2'd2, 1'b1, 1'b0, 7'b0000000, 8'd0, 3'd0)
  };

  function automatic logic [6:0] strobes();
    return {env_arm, env_fire, len_clk, sweep_clk, env_step, env_dec, sweep_sub};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic v, input logic h);
    @(negedge clk);
    div_fall = (op == 2'd0);
    div_rise = (op == 2'd1);
    pwr_wr   = (op == 2'd2);
    pwr_val  = v;
    div_high = h;
    @(negedge clk);
    div_fall = 1'b0; div_rise = 1'b0; pwr_wr = 1'b0; pwr_val = 1'b0; div_high = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int ssub_n, dec_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset", {strobes(), ev_count, 1'b0, step}, 32'd0);

    // table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][23:22], VEC[i][21], VEC[i][20]);
      chk($sformatf("vec %0d R1 R2 R3 R5 R6 R7 R8 R9", i),
          {strobes(), 1'b0, ev_count, 1'b0, step}, {8'd0, VEC[i][19:0]} & 32'h7FFFF | {12'd0, VEC[i][19:13], 1'b0, VEC[i][11:0]});
      chk($sformatf("vec %0d R10", i), len_phase, VEC[i][4]);
      @(negedge clk);
      chk($sformatf("vec %0d R4 one-cycle", i), strobes(), 7'd0);
    end

    // R7 R6: pending skip cancelled by a power cycle
    apply(2'd2, 1'b0, 1'b0);
    apply(2'd2, 1'b1, 1'b1);
    chk("R7 seed", ev_count, 8'd1);
    apply(2'd2, 1'b0, 1'b0);
    apply(2'd2, 1'b1, 1'b0);
    chk("R6 power-on clears", ev_count, 8'd0);
    apply(2'd0, 1'b0, 1'b0);
    chk("R6 skip cleared", {strobes(), ev_count}, {7'b0110000, 8'd1});

    // R5 edge during a power write is ignored
    @(negedge clk);
    div_fall = 1'b1; pwr_wr = 1'b1; pwr_val = 1'b1;
    @(negedge clk);
    div_fall = 1'b0; pwr_wr = 1'b0; pwr_val = 1'b0;
    chk("R5 edge with power write", {strobes(), ev_count, 1'b0, step}, {7'd0, 8'd1, 1'b0, 3'd1});

    // R9: 16 consecutive serviced events
    ssub_n = 0; dec_n = 0;
    for (int k = 0; k < 16; k++) begin
      apply(2'd0, 1'b0, 1'b0);
      ssub_n += int'(sweep_sub);
      dec_n  += int'(env_dec);
    end
    chk("R9 sweep sub-ticks in 16", ssub_n, 4);
    chk("R9 decrements in 16", dec_n, 2);
    chk("R1 step after 17", step, 3'd1);

    // R8 wrap
    while (ev_count != 8'd255) apply(2'd0, 1'b0, 1'b0);
    apply(2'd0, 1'b0, 1'b0);
    chk("R8 wrap", ev_count, 8'd0);
    chk("R10 phase at wrap", len_phase, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule